// File: doc/BRIEF.md
# Configurable Bidirectional Pin Cell

This block is the programmable cell behind one package pin. On the way out, it picks its data from either the routed logic path or a short bypass path, and it can invert that data. It then decides whether to drive the pin at all. The drive enable can be fixed on or off, taken from a shared product-term enable, or taken from one of two global enables. The driver runs in totem-pole mode or in open-drain mode, in which it only ever pulls low. A pull-up request is raised for every unused cell, and used cells can ask for it as a configuration option.

On the way in, the cell reads the pin itself, so a cell that is driving sees its own value. It returns the pin state to the routing in one of three forms: straight through, through an edge-triggered register, or through a level-sensitive latch. The register and the latch run on whichever of two I/O clocks the cell selects. The active-low global reset is always wired to the cell and clears the stored value.

All configuration arrives as static inputs. A cell can therefore act as an input, a registered or latched input, an output, a tristated output or a bidirectional pin, with no change to its structure.

Top module: `pin_cell`

## Requirements
- R1: The outgoing data is `d_bypass` when `cfg_bypass`=1 and `d_route` when `cfg_bypass`=0.
- R2: When `cfg_invert`=1 the outgoing data is the complement of the selected source. When `cfg_invert`=0 it is passed unchanged.
- R3: The enable code `cfg_oe_sel` selects the drive enable as follows: 0 never drives, 1 always drives, 2 follows `pt_oe`, 3 follows `genable0`, 4 follows `genable1`. Codes 5 to 7 never drive.
- R4: When `cfg_open_drain`=1, an enabled cell drives 0 for data 0 and leaves the pin at high impedance for data 1. When `cfg_open_drain`=0, an enabled cell drives both levels.
- R5: When `cfg_used`=0 the cell never drives and `pull_en`=1. When `cfg_used`=1, `pull_en` equals `cfg_pullup`.
- R6: With `cfg_in_mode` 0 or 3, `in_to_route` follows the resolved pin level combinationally, including the value the cell drives itself.
- R7: With `cfg_in_mode`=1, `in_to_route` takes the pin level on each rising edge of the selected I/O clock and holds it between edges.
- R8: With `cfg_in_mode`=2, `in_to_route` follows the pin while the selected I/O clock is high and holds the last value while that clock is low.
- R9: `cfg_clk_sel`=0 selects `ioclk0` for the storage element, and `cfg_clk_sel`=1 selects `ioclk1`.
- R10: While `rst_n`=0 the stored input value is 0, at once and without waiting for a clock, in both register and latch mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Global reset, active low, asynchronous |
| ioclk0 | input | 1 | I/O clock 0 |
| ioclk1 | input | 1 | I/O clock 1 |
| d_route | input | 1 | Output data from the routed path |
| d_bypass | input | 1 | Output data from the fast bypass path |
| pt_oe | input | 1 | Shared product-term output enable |
| genable0 | input | 1 | Global output enable 0 |
| genable1 | input | 1 | Global output enable 1 |
| cfg_used | input | 1 | 1 when the pin is in use in the design |
| cfg_bypass | input | 1 | Output source select, 1 selects the bypass |
| cfg_invert | input | 1 | Output polarity, 1 selects active low |
| cfg_oe_sel | input | 3 | Drive enable source code |
| cfg_open_drain | input | 1 | 1 selects open-drain drive |
| cfg_pullup | input | 1 | Pull-up request for a used pin |
| cfg_in_mode | input | 2 | Input path: 0/3 direct, 1 register, 2 latch |
| cfg_clk_sel | input | 1 | Storage clock select |
| pad | inout | 1 | The pin, modelled as a tri-state net |
| pull_en | output | 1 | Request for the pin pull-up |
| in_to_route | output | 1 | Input value returned to the routing |

## Verification
The assertions assume that the configuration inputs, the data inputs and the pin stay steady across every rising edge of `ioclk0`. They also assume that the pin is never left floating while its value is being sampled. The stimulus respects both assumptions. It changes every input 1 ns before the midpoint of a bench clock period, where neither I/O clock has an edge. Whenever the cell releases the pin, the bench either drives the pin externally or models the requested pull-up. The clock select is only changed while reset is held, so switching clocks never creates a false storage edge. Each latch hold check is made in the low phase of the selected clock, right after a change of pin value.

// File: rtl/pin_cell.sv
`timescale 1ns/1ps
module pin_cell (
  input  logic       rst_n,
  input  logic       ioclk0,
  input  logic       ioclk1,
  input  logic       d_route,
  input  logic       d_bypass,
  input  logic       pt_oe,
  input  logic       genable0,
  input  logic       genable1,
  input  logic       cfg_used,
  input  logic       cfg_bypass,
  input  logic       cfg_invert,
  input  logic [2:0] cfg_oe_sel,
  input  logic       cfg_open_drain,
  input  logic       cfg_pullup,
  input  logic [1:0] cfg_in_mode,
  input  logic       cfg_clk_sel,
  inout  tri         pad,
  output logic       pull_en,
  output logic       in_to_route
);

  localparam logic [2:0] OE_OFF  = 3'd0;
  localparam logic [2:0] OE_ON   = 3'd1;
  localparam logic [2:0] OE_PT   = 3'd2;
  localparam logic [2:0] OE_G0   = 3'd3;
  localparam logic [2:0] OE_G1   = 3'd4;
  localparam logic [1:0] IN_REG  = 2'd1;
  localparam logic [1:0] IN_LAT  = 2'd2;

  logic dout, oe_pick, drv_en, drv_val;
  logic store_clk, pin_val, ff_q, lat_q;

  assign dout = (cfg_bypass ? d_bypass : d_route) ^ cfg_invert;

  always_comb begin
    case (cfg_oe_sel)
      OE_OFF:  oe_pick = 1'b0;
      OE_ON:   oe_pick = 1'b1;
      OE_PT:   oe_pick = pt_oe;
      OE_G0:   oe_pick = genable0;
      OE_G1:   oe_pick = genable1;
      default: oe_pick = 1'b0;
    endcase
  end

  assign drv_en  = cfg_used & oe_pick & ~(cfg_open_drain & dout);
  assign drv_val = cfg_open_drain ? 1'b0 : dout;
  assign pad     = drv_en ? drv_val : 1'bz;
  assign pull_en = ~cfg_used | cfg_pullup;

  assign pin_val   = pad;
  assign store_clk = cfg_clk_sel ? ioclk1 : ioclk0;

  always_ff @(posedge store_clk or negedge rst_n) begin
    if (!rst_n) ff_q <= 1'b0;
    else        ff_q <= pin_val;
  end

  always_latch begin
    if (!rst_n)         lat_q = 1'b0;
    else if (store_clk) lat_q = pin_val;
  end

  always_comb begin
    case (cfg_in_mode)
      IN_REG:  in_to_route = ff_q;
      IN_LAT:  in_to_route = lat_q;
      default: in_to_route = pin_val;
    endcase
  end

endmodule

// File: rtl/pin_cell_chk.sv
`timescale 1ns/1ps
module pin_cell_chk (
  input logic       rst_n,
  input logic       ioclk0,
  input logic       pin,
  input logic       drv_en,
  input logic       d_route,
  input logic       d_bypass,
  input logic       cfg_used,
  input logic       cfg_bypass,
  input logic       cfg_invert,
  input logic [2:0] cfg_oe_sel,
  input logic       cfg_open_drain,
  input logic [1:0] cfg_in_mode,
  input logic       cfg_clk_sel,
  input logic       in_to_route
);

  // R3
  oe_off_chk: assert property (@(posedge ioclk0) disable iff (!rst_n)
    (cfg_oe_sel == 3'd0 || cfg_oe_sel > 3'd4) |-> !drv_en);

  // R1
  out_data_chk: assert property (@(posedge ioclk0) disable iff (!rst_n)
    (cfg_used && cfg_oe_sel == 3'd1 && !cfg_open_drain)
      |-> pin == ((cfg_bypass ? d_bypass : d_route) ^ cfg_invert));

  // R4
  od_low_only_chk: assert property (@(posedge ioclk0) disable iff (!rst_n)
    (cfg_open_drain && drv_en) |-> pin == 1'b0);

  // R5
  unused_quiet_chk: assert property (@(posedge ioclk0) disable iff (!rst_n)
    !cfg_used |-> !drv_en);

  // R7
  reg_capture_chk: assert property (@(posedge ioclk0) disable iff (!rst_n)
    (cfg_in_mode == 2'd1 && !cfg_clk_sel)
      |=> (cfg_in_mode != 2'd1 || cfg_clk_sel || in_to_route == $past(pin)));

  // R10
  always @(negedge ioclk0)
    if (!rst_n && (cfg_in_mode == 2'd1 || cfg_in_mode == 2'd2))
      rst_clear_chk: assert (in_to_route == 1'b0);

endmodule

bind pin_cell pin_cell_chk u_chk (
  .rst_n(rst_n), .ioclk0(ioclk0), .pin(pad), .drv_en(drv_en),
  .d_route(d_route), .d_bypass(d_bypass), .cfg_used(cfg_used),
  .cfg_bypass(cfg_bypass), .cfg_invert(cfg_invert), .cfg_oe_sel(cfg_oe_sel),
  .cfg_open_drain(cfg_open_drain), .cfg_in_mode(cfg_in_mode),
  .cfg_clk_sel(cfg_clk_sel), .in_to_route(in_to_route)
);

// File: tb/sim_pin_cell.sv
`timescale 1ns/1ps
module sim_pin_cell;

  logic clk = 1'b0, ioclk1 = 1'b0, rst_n = 1'b0;
  logic d_route = 0, d_bypass = 0, pt_oe = 0, genable0 = 0, genable1 = 0;
  logic used = 1, byp = 0, inv = 0, od = 0, pu = 0, csel = 0;
  logic [2:0] oesel = 3'd0;
  logic [1:0] mode = 2'd1;
  logic ext_drv = 1, ext_val = 1;
  tri   pad;
  logic pull_en, in_to_route;
  int   checks = 0, errors = 0;
  bit   done = 0;

  always #4 clk = ~clk;
  initial begin #6; forever #8 ioclk1 = ~ioclk1; end

  pin_cell u0 (
    .rst_n(rst_n), .ioclk0(clk), .ioclk1(ioclk1), .d_route(d_route),
    .d_bypass(d_bypass), .pt_oe(pt_oe), .genable0(genable0), .genable1(genable1),
    .cfg_used(used), .cfg_bypass(byp), .cfg_invert(inv), .cfg_oe_sel(oesel),
    .cfg_open_drain(od), .cfg_pullup(pu), .cfg_in_mode(mode), .cfg_clk_sel(csel),
    .pad(pad), .pull_en(pull_en), .in_to_route(in_to_route)
  );

  // behavioural reference
  logic e_out, e_oe, e_en, e_pull, tb_en, tb_val, e_pad, m_ff, m_lat, e_in;

  always @* begin
    e_out = byp ? d_bypass : d_route;
    if (inv) e_out = !e_out;
    if (oesel == 3'd1)      e_oe = 1;
    else if (oesel == 3'd2) e_oe = pt_oe;
    else if (oesel == 3'd3) e_oe = genable0;
    else if (oesel == 3'd4) e_oe = genable1;
    else                    e_oe = 0;
    e_en = used && e_oe && !(od && e_out);
    e_pull = !used || pu;
    tb_en = !e_en && (ext_drv || e_pull);
    tb_val = ext_drv ? ext_val : 1'b1;
    if (e_en)       e_pad = od ? 1'b0 : e_out;
    else if (tb_en) e_pad = tb_val;
    else            e_pad = 1'bz;
  end

  assign pad = tb_en ? tb_val : 1'bz;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) m_ff = 0; else if (!csel) m_ff = e_pad;
  always @(posedge ioclk1 or negedge rst_n)
    if (!rst_n) m_ff = 0; else if (csel) m_ff = e_pad;
  always @* begin
    if (!rst_n) m_lat = 0;
    else if (csel ? ioclk1 : clk) m_lat = e_pad;
  end
  always @* e_in = (mode == 2'd1) ? m_ff : (mode == 2'd2) ? m_lat : e_pad;

  task automatic chk(string tag);
    checks++;
    if (pad !== e_pad || in_to_route !== e_in || pull_en !== e_pull) begin
      errors++;
      $display("FAIL %s pad=%b exp %b in=%b exp %b pull=%b exp %b",
               tag, pad, e_pad, in_to_route, e_in, pull_en, e_pull);
    end
  endtask

  task automatic step(string tag);
    @(negedge clk); #3; chk(tag);
  endtask

  task automatic peek(string tag);
    #0.5; chk(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R10 reset state, register mode
    step("R10");
    rst_n = 1; ext_val = 1;
    step("R7");
    ext_val = 0; peek("R7");
    step("R7");
    for (int i = 0; i < 4; i++) begin ext_val = i[0]; step("R7"); end
    // R6 direct input
    mode = 2'd0; ext_val = 1; peek("R6");
    mode = 2'd3; ext_val = 0; peek("R6");
    step("R6");
    // R8 latch on ioclk0
    mode = 2'd2; ext_val = 1; step("R8");
    ext_val = 0; peek("R8");
    step("R8");
    // R9 switch to ioclk1 under reset
    rst_n = 0; peek("R10");
    csel = 1; step("R9");
    rst_n = 1; mode = 2'd1;
    for (int i = 0; i < 6; i++) begin ext_val = (i % 3 == 0); step("R9"); end
    mode = 2'd2;
    step("R8");
    if (ioclk1) step("R8");
    ext_val = !ext_val; peek("R8");
    step("R8");
    ext_val = 1; step("R8"); step("R8");
    // R10 async clear of latched value
    rst_n = 0; peek("R10");
    step("R10");
    rst_n = 1; csel = 0;
    rst_n = 0; step("R9");
    rst_n = 1; step("R9");
    // R1 R2 output path, seen on own input R6
    mode = 2'd0; oesel = 3'd1; ext_drv = 0;
    for (int i = 0; i < 16; i++) begin
      {byp, inv, d_route, d_bypass} = 4'(i);
      step(i < 8 ? "R1" : "R2");
    end
    mode = 2'd1; d_route = 1; byp = 0; inv = 0; step("R6");
    d_route = 0; step("R6");
    // R3 enable sources
    mode = 2'd0; ext_drv = 1; ext_val = 0; d_route = 1;
    for (int s = 0; s < 8; s++) begin
      oesel = 3'(s);
      pt_oe = 0; genable0 = 0; genable1 = 0; step("R3");
      pt_oe = 1; genable0 = 0; genable1 = 0; step("R3");
      pt_oe = 0; genable0 = 1; genable1 = 0; step("R3");
      pt_oe = 0; genable0 = 0; genable1 = 1; step("R3");
    end
    // R4 open drain, with pull-up for release
    oesel = 3'd1; od = 1; pu = 1; ext_drv = 0;
    d_route = 0; step("R4");
    d_route = 1; step("R4");
    inv = 1; step("R4");
    od = 0; step("R4");
    inv = 0; step("R4");
    // R5 unused pin and pull-up option
    used = 0; pu = 0; ext_drv = 1; ext_val = 0; d_route = 1; step("R5");
    ext_drv = 0; step("R5");
    used = 1; pu = 0; ext_drv = 0; step("R5");
    pu = 1; oesel = 3'd0; step("R5");
    finish_run();
  end

endmodule